// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block turns the system clock into the two timing strobes that a serial port's shift logic needs. The first is a bit-rate strobe. The second is a strobe at sixteen times the bit rate, which the receiver uses to oversample the line. Each strobe is a pulse one clock cycle wide. The receiver and transmitter themselves sit elsewhere and only use these strobes.

There are three families of rate. The synchronous rate is fixed at one bit per twelve clocks. The fixed asynchronous rate is a divide by 64 of the clock, or a divide by 32 when the speed-doubling input is set. The programmable rates come from one of two auto-reload counters. The narrow counter counts clock-divided-by-twelve strobes. The wide counter counts every clock. On overflow, each counter reloads from its own reload input. In the asynchronous families, the chosen overflow or fixed strobe passes through an optional halving stage and then a divide by 16. The strobe taken between those two stages is the oversampling strobe. The doubling input bypasses the halving stage, except when the wide counter is the source: that source always halves.

Top module: `baud_tick_gen`

## Requirements
- R1: With rate_mode = 2'b00 (synchronous), bit_tick pulses once every 12 clocks and os_tick stays low.
- R2: With rate_mode = 2'b01 (fixed asynchronous) and dbl = 0, bit_tick has a period of 64 clocks and os_tick has a period of 4 clocks.
- R3: With rate_mode = 2'b01 and dbl = 1, bit_tick has a period of 32 clocks and os_tick has a period of 2 clocks.
- R4: With rate_mode = 2'b10 and src_wide = 0, the bit_tick period is 12 × (256 − reload8) × 32 clocks when dbl = 0, and half that when dbl = 1. The os_tick period is one sixteenth of the bit_tick period.
- R5: With rate_mode = 2'b10 and src_wide = 1, the bit_tick period is 32 × (65536 − reload16) clocks and the os_tick period is 2 × (65536 − reload16) clocks, whatever the value of dbl.
- R6: In every asynchronous setting, each bit_tick occurs in the same cycle as an os_tick, and exactly 16 os_tick pulses fall in each bit period, counting the one that coincides with the closing bit_tick.
- R7: A new reload value does not cut short the count already in progress. It is used only from the next overflow onward.
- R8: While rst_n is low, both bit_tick and os_tick are low.
- R9: rate_mode = 2'b11 behaves the same as 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_mode | input | 2 | 00 synchronous, 01 fixed asynchronous, 10/11 counter-based |
| src_wide | input | 1 | Counter source: 0 narrow counter with prescaler, 1 wide counter |
| dbl | input | 1 | Speed doubling: bypasses the halving stage |
| reload8 | input | 8 | Reload value of the narrow counter |
| reload16 | input | 16 | Reload value of the wide counter |
| bit_tick | output | 1 | Bit-rate strobe, one cycle wide |
| os_tick | output | 1 | 16x oversampling strobe, one cycle wide |

## Verification
A wrong prescaler count or a wrong reload shows up as a changed strobe period as soon as the next overflow happens, so the bench measures the spacing between pulses instead of their absolute phase. A halving flop that is stuck or wrongly gated changes the os_tick period by a factor of two within two source strobes. A fault in the divide-by-16 counter appears within one bit period as a wrong number of os_tick pulses between bit_ticks. A reload that is applied too early shortens the first interval after a write, and this is visible at the very next overflow.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    RM_SYNC   = 2'b00,
    RM_FIXED  = 2'b01,
    RM_TIMER  = 2'b10,
    RM_TIMER2 = 2'b11
  } rate_mode_e;

  function automatic logic is_timer(input rate_mode_e m);
    return m[1];
  endfunction

  // halving stage is active unless doubled; wide source always halves
  function automatic logic halve_active(input rate_mode_e m, input logic wide,
                                        input logic dbl);
    return (is_timer(m) && wide) ? 1'b1 : !dbl;
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // a divider above one never emits two strobes back to back (R1)
  assert_presc_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/baud_reload_ctr.sv
module baud_reload_ctr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] reload,
  output logic             ovf
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (en) begin
      if (cnt == TOP)  cnt <= reload;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign ovf = en && (cnt == TOP);

  // the count only moves on an enable strobe; a reload write alone leaves it (R7)
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/baud_post_div.sv
module baud_post_div #(
  parameter int OS_RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_tick,
  input  logic halve_en,
  output logic os_tick,
  output logic bit_tick
);
  localparam int OW = $clog2(OS_RATIO);
  localparam logic [OW-1:0] OS_LAST = OW'(OS_RATIO - 1);

  logic          half;
  logic [OW-1:0] os_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    half <= 1'b0;
    else if (pre_tick && halve_en) half <= ~half;
  end

  assign os_tick = pre_tick && (half || !halve_en);

  always_ff @(posedge clk) begin
    if (!rst_n)       os_cnt <= '0;
    else if (os_tick) os_cnt <= (os_cnt == OS_LAST) ? '0 : os_cnt + 1'b1;
  end

  assign bit_tick = os_tick && (os_cnt == OS_LAST);

  // with halving on, two source strobes are needed per oversample strobe (R4)
  assert_halve_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && halve_en && $past(halve_en)) |-> !$past(os_tick));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int SYNC_DIV   = 12,
  parameter int FIXED_PRE  = 2,
  parameter int NARROW_W   = 8,
  parameter int WIDE_W     = 16,
  parameter int OS_RATIO   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  rate_mode,
  input  logic        src_wide,
  input  logic        dbl,
  input  logic [7:0]  reload8,
  input  logic [15:0] reload16,
  output logic        bit_tick,
  output logic        os_tick
);
  rate_mode_e mode;
  logic presc_tick, fixed_tick, ovf_narrow, ovf_wide;
  logic pre_tick, halve_en, post_os, post_bit;

  assign mode = rate_mode_e'(rate_mode);

  baud_prescaler #(.DIV(SYNC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(presc_tick));

  baud_prescaler #(.DIV(FIXED_PRE)) u_fixed (
    .clk(clk), .rst_n(rst_n), .tick(fixed_tick));

  baud_reload_ctr #(.WIDTH(NARROW_W)) u_narrow (
    .clk(clk), .rst_n(rst_n), .en(presc_tick),
    .reload(NARROW_W'(reload8)), .ovf(ovf_narrow));

  baud_reload_ctr #(.WIDTH(WIDE_W)) u_wide (
    .clk(clk), .rst_n(rst_n), .en(1'b1),
    .reload(WIDE_W'(reload16)), .ovf(ovf_wide));

  always_comb begin
    unique case (mode)
      RM_SYNC:  pre_tick = 1'b0;
      RM_FIXED: pre_tick = fixed_tick;
      default:  pre_tick = src_wide ? ovf_wide : ovf_narrow;
    endcase
  end

  assign halve_en = halve_active(mode, src_wide, dbl);

  baud_post_div #(.OS_RATIO(OS_RATIO)) u_post (
    .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .halve_en(halve_en),
    .os_tick(post_os), .bit_tick(post_bit));

  assign bit_tick = (mode == RM_SYNC) ? presc_tick : post_bit;
  assign os_tick  = (mode == RM_SYNC) ? 1'b0 : post_os;

  assert_sync_no_os_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_SYNC) |-> !os_tick);

  assert_bit_on_os_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && mode != RM_SYNC) |-> os_tick);

  assert_sync_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && mode == RM_SYNC) |=> !bit_tick);
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rate_mode = 2'b00;
  logic src_wide = 1'b0, dbl = 1'b0;
  logic [7:0] reload8 = 8'd255;
  logic [15:0] reload16 = 16'hFFFF;
  logic bit_tick, os_tick;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  baud_tick_gen dut (
    .clk(clk), .rst_n(rst_n), .rate_mode(rate_mode), .src_wide(src_wide),
    .dbl(dbl), .reload8(reload8), .reload16(reload16),
    .bit_tick(bit_tick), .os_tick(os_tick));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
      summary();
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic next_gap(input bit on_bit, output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!(on_bit ? bit_tick : os_tick));
  endtask

  // independent rate model
  function automatic int exp_bit(input logic [1:0] m, input logic w, input logic d,
                                 input int r8, input int r16);
    int src;
    if (m == 2'b00) return 12;
    if (m == 2'b01) return d ? 32 : 64;
    if (w) return (65536 - r16) * 32;
    src = 12 * (256 - r8);
    return d ? src * 16 : src * 32;
  endfunction

  task automatic run_cfg(input logic [1:0] m, input logic w, input logic d,
                         input int r8, input int r16, input string tag);
    int g, eb, nos;
    @(negedge clk);
    rate_mode = m; src_wide = w; dbl = d;
    reload8 = 8'(r8); reload16 = 16'(r16);
    eb = exp_bit(m, w, d, r8, r16);
    next_gap(1'b1, g); next_gap(1'b1, g); next_gap(1'b1, g);
    chk(g, eb, {tag, " bit period"});
    next_gap(1'b1, g);
    if (m != 2'b00) begin
      // os ticks up to and including the next bit tick
      nos = 0;
      do begin
        @(negedge clk);
        if (os_tick) nos++;
      end while (!bit_tick);
      chk(nos, 16, {tag, " R6 os per bit"});
      next_gap(1'b0, g);
      chk(g, eb / 16, {tag, " os period"});
    end else begin
      nos = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (os_tick) nos++;
      end
      chk(nos, 0, {tag, " os silent"});
    end
  endtask

  initial begin
    int g;
    // R8: outputs quiet in reset
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(int'(bit_tick) + int'(os_tick), 0, "R8 reset quiet");
    end
    rst_n = 1'b1;

    run_cfg(2'b00, 1'b0, 1'b0, 255, 65535, "R1 sync");
    run_cfg(2'b00, 1'b0, 1'b1, 255, 65535, "R1 sync dbl");
    run_cfg(2'b01, 1'b0, 1'b0, 255, 65535, "R2 fixed");
    run_cfg(2'b01, 1'b0, 1'b1, 255, 65535, "R3 fixed dbl");
    for (int r = 252; r <= 255; r++)
      for (int d = 0; d < 2; d++)
        run_cfg(2'b10, 1'b0, 1'(d), r, 65535, "R4 narrow");
    for (int r = 65528; r <= 65535; r++)
      for (int d = 0; d < 2; d++)
        run_cfg(2'b10, 1'b1, 1'(d), 255, r, "R5 wide");
    run_cfg(2'b11, 1'b0, 1'b1, 254, 65535, "R9 alt narrow");
    run_cfg(2'b11, 1'b1, 1'b0, 255, 65531, "R9 alt wide");

    // R7: reload written mid-count applies from next overflow
    @(negedge clk);
    rate_mode = 2'b10; src_wide = 1'b0; dbl = 1'b1; reload8 = 8'd250;
    next_gap(1'b0, g); next_gap(1'b0, g); next_gap(1'b0, g);
    @(negedge clk);
    reload8 = 8'd200;
    next_gap(1'b0, g);
    chk(g + 1, 72, "R7 old reload kept");
    next_gap(1'b0, g);
    chk(g, 672, "R7 new reload used");

    summary();
  end
endmodule